// File: doc/BRIEF.md
# Colour Adjustment Matrix Stage

This stage sits in a display output path, just ahead of the output gamma stage. It takes one RGB pixel per cycle, with 10 bits per component. It multiplies the pixel by a programmable 3x3 matrix of signed fixed-point coefficients and adds a signed offset to each output channel. Each result is rounded and then clamped to the legal component range. A single enable flag turns the transform off. The pixel then comes out bit-for-bit unchanged, with the same delay as the transformed path.

Software writes twelve coefficients and the enable flag through a small register write port. These writes land in a shadow copy only. A commit request arms the new set. The whole set, coefficients and enable together, becomes active on the next start-of-frame pixel. A frame therefore never mixes old and new settings. Once a commit is armed, further writes are dropped until that commit has taken effect.

Top module: `color_matrix`

## Requirements
- R1: After reset, out_valid is low, the enable is off so pixels pass through unchanged, and both coefficient sets hold the identity matrix (coefficients 0, 4 and 8 equal 0x1000) with zero offsets.
- R2: The coefficient for index k (0 to 11) is written at byte address 4*k, taking its value from cfg_wdata[14:0]. The control register sits at byte address 0x40: cfg_wdata[4] is the enable and cfg_wdata[0] set to 1 requests a commit.
- R3: When enabled, output channel i (0 = red, 1 = green, 2 = blue) equals c[3i]*R + c[3i+1]*G + c[3i+2]*B + o[i]. Each coefficient c is signed two's complement with 12 fraction bits (0x1000 = 1.0). The offset o[i] is coefficient 9+i, read as a signed whole number of output codes.
- R4: The full-precision sum is rounded half-up at the 12-bit fraction point, so 0.5 gives 1 and 1.5 gives 2.
- R5: Each rounded result is clamped to 0..1023, so negative sums give 0 and sums above 1023 give 1023.
- R6: With the active enable clear, each output component equals the corresponding input component exactly.
- R7: Every accepted pixel appears on the outputs exactly 3 clock edges after the edge that samples it, with out_valid following pix_valid at that delay, in both the transform and the bypass path.
- R8: Coefficient and enable writes that are not followed by a commit have no effect on output pixels.
- R9: After a commit request, pixels keep using the old settings until a pixel arrives with pix_valid and pix_sof both high. That pixel, and every pixel after it, uses the complete new set of coefficients and enable.
- R10: Any write (coefficient or control) made while a commit is armed and not yet applied is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Byte address of the register write |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Input pixel valid |
| pix_sof | input | 1 | Input pixel is the first of a frame |
| pix_r | input | 10 | Input red component |
| pix_g | input | 10 | Input green component |
| pix_b | input | 10 | Input blue component |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 10 | Output red component |
| out_g | output | 10 | Output green component |
| out_b | output | 10 | Output blue component |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that pix_sof is only meaningful together with pix_valid: a commit is taken on a start-of-frame marker only when a valid pixel carries it. The stimulus meets both assumptions by changing every input only on the falling clock edge and by always driving a defined level. Frame markers are placed only on valid pixels. Writes land both while a commit is armed and while none is, so the drop rule and the shadow hold are both exercised.

// File: rtl/color_matrix.sv
module color_matrix #(
  parameter int COMP_W     = 10,
  parameter int COEF_W     = 15,
  parameter int FRAC_W     = 12,
  parameter int N_COEF     = 12,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CTRL_ADDR  = 'h40,
  parameter int EN_BIT     = 4,
  parameter int COMMIT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              pix_valid,
  input  logic              pix_sof,
  input  logic [COMP_W-1:0] pix_r,
  input  logic [COMP_W-1:0] pix_g,
  input  logic [COMP_W-1:0] pix_b,
  output logic              out_valid,
  output logic [COMP_W-1:0] out_r,
  output logic [COMP_W-1:0] out_g,
  output logic [COMP_W-1:0] out_b
);
  localparam int IDX_W  = $clog2(N_COEF);
  localparam int PROD_W = COMP_W + COEF_W + 1;
  localparam int ACC_W  = PROD_W + 3;
  localparam logic [IDX_W-1:0]        LAST_IDX = IDX_W'(N_COEF - 1);
  localparam logic [COEF_W-1:0]       UNITY    = COEF_W'(1 << FRAC_W);
  localparam logic signed [ACC_W-1:0] HALF     = ACC_W'(1 << (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] TOP      = ACC_W'((1 << COMP_W) - 1);

  typedef logic [N_COEF-1:0][COEF_W-1:0] bank_t;

  function automatic bank_t unity_bank();
    bank_t b = '0;
    for (int k = 0; k < 3; k++) b[4*k] = UNITY;
    return b;
  endfunction

  bank_t shadow, active, cur;
  logic  sh_en, act_en, cur_en, pend;

  wire commit_now = pend & pix_valid & pix_sof;
  assign cur    = commit_now ? shadow : active;
  assign cur_en = commit_now ? sh_en  : act_en;

  wire [IDX_W-1:0] widx = cfg_addr[IDX_W+1:2];
  wire coef_hit = (cfg_addr[1:0] == 2'b00) && (cfg_addr[ADDR_W-1:IDX_W+2] == '0) && (widx <= LAST_IDX);
  wire ctrl_hit = (cfg_addr == ADDR_W'(CTRL_ADDR));
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= unity_bank();
      active <= unity_bank();
      sh_en  <= 1'b0;
      act_en <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (commit_now) begin
        active <= shadow;
        act_en <= sh_en;
        pend   <= 1'b0;
      end
      if (cfg_we && !pend) begin
        if (ctrl_hit) begin
          sh_en <= cfg_wdata[EN_BIT];
          if (cfg_wdata[COMMIT_BIT]) pend <= 1'b1;
        end else if (coef_hit) begin
          shadow[widx] <= cfg_wdata[COEF_W-1:0];
        end
      end
    end
  end

  logic [2:0][COMP_W-1:0] pin;
  assign pin = {pix_b, pix_g, pix_r};

  logic                         s1_v, s2_v, s3_v;
  logic                         s1_en, s2_en;
  logic [2:0][COMP_W-1:0]       s1_pix, s2_pix, o;
  logic signed [PROD_W-1:0]     s1_prod [9];
  logic signed [COEF_W-1:0]     s1_off  [3];
  logic signed [ACC_W-1:0]      s2_acc  [3];
  logic signed [ACC_W-1:0]      q       [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {s1_v, s2_v, s3_v} <= '0;
    else        {s1_v, s2_v, s3_v} <= {pix_valid, s1_v, s2_v};
  end

  always_ff @(posedge clk) begin
    s1_en  <= cur_en;
    s1_pix <= pin;
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++)
        s1_prod[3*i+j] <= PROD_W'($signed({1'b0, pin[j]})) * PROD_W'($signed(cur[3*i+j]));
      s1_off[i] <= $signed(cur[9+i]);
    end
  end

  always_ff @(posedge clk) begin
    s2_en  <= s1_en;
    s2_pix <= s1_pix;
    for (int i = 0; i < 3; i++)
      s2_acc[i] <= ACC_W'(s1_prod[3*i]) + ACC_W'(s1_prod[3*i+1]) + ACC_W'(s1_prod[3*i+2])
                 + (ACC_W'(s1_off[i]) <<< FRAC_W) + HALF;
  end

  always_comb begin
    for (int i = 0; i < 3; i++) q[i] = s2_acc[i] >>> FRAC_W;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (!s2_en)          o[i] <= s2_pix[i];
      else if (q[i] < 0)   o[i] <= '0;
      else if (q[i] > TOP) o[i] <= '1;
      else                 o[i] <= q[i][COMP_W-1:0];
    end
  end

  assign out_valid = s3_v;
  assign out_r     = o[0];
  assign out_g     = o[1];
  assign out_b     = o[2];
endmodule

// File: rtl/color_matrix_chk.sv
module color_matrix_chk #(
  parameter int COMP_W = 10,
  parameter int COEF_W = 15,
  parameter int N_COEF = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic                     pix_valid,
  input logic                     pix_sof,
  input logic [COMP_W-1:0]        pix_r,
  input logic [COMP_W-1:0]        pix_g,
  input logic [COMP_W-1:0]        pix_b,
  input logic                     out_valid,
  input logic [COMP_W-1:0]        out_r,
  input logic [COMP_W-1:0]        out_g,
  input logic [COMP_W-1:0]        out_b,
  input logic                     pend,
  input logic                     cur_en,
  input logic [N_COEF*COEF_W-1:0] shadow,
  input logic [N_COEF*COEF_W-1:0] active
);
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= '0;
    else if (seen != 3) seen <= seen + 2'd1;
  end

  // R7
  latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3) |-> (out_valid == $past(pix_valid, 3)));

  // R6
  bypass_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((seen == 2'd3) && $past(pix_valid && !cur_en, 3)) |->
      (out_r == $past(pix_r, 3) && out_g == $past(pix_g, 3) && out_b == $past(pix_b, 3)));

  // R10
  locked_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cfg_we) |=> $stable(shadow));

  // R9
  commit_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && pix_valid && pix_sof) |=> (!pend && active == $past(shadow)));

  // R8
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && pix_valid && pix_sof) |=> $stable(active));
endmodule

bind color_matrix color_matrix_chk #(
  .COMP_W(COMP_W), .COEF_W(COEF_W), .N_COEF(N_COEF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
  .pix_valid(pix_valid), .pix_sof(pix_sof),
  .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
  .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
  .pend(pend), .cur_en(cur_en), .shadow(shadow), .active(active)
);

// File: tb/color_matrix_tb.sv
module color_matrix_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pix_valid = 1'b0, pix_sof = 1'b0;
  logic [9:0]  pix_r = '0, pix_g = '0, pix_b = '0;
  logic        out_valid;
  logic [9:0]  out_r, out_g, out_b;

  always #4 clk = ~clk;

  color_matrix u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  int  sh_m[12], ac_m[12];
  bit  sh_en_m, ac_en_m, pend_m;

  bit          h_v[3];
  logic [29:0] h_d[3];
  string       h_tag[3];

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic int sx15(logic [14:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [29:0] model_px(logic [9:0] r, logic [9:0] g, logic [9:0] b);
    logic [9:0] ch[3];
    longint acc, qq;
    if (!ac_en_m) return {r, g, b};
    for (int i = 0; i < 3; i++) begin
      acc = longint'(ac_m[3*i]) * r + longint'(ac_m[3*i+1]) * g + longint'(ac_m[3*i+2]) * b
          + longint'(ac_m[9+i]) * 4096 + 2048;
      qq = acc >>> 12;
      ch[i] = (qq < 0) ? 10'd0 : (qq > 1023) ? 10'd1023 : qq[9:0];
    end
    return {ch[0], ch[1], ch[2]};
  endfunction

  task automatic reset_model();
    for (int k = 0; k < 12; k++) begin
      sh_m[k] = (k == 0 || k == 4 || k == 8) ? 4096 : 0;
      ac_m[k] = sh_m[k];
    end
    sh_en_m = 0; ac_en_m = 0; pend_m = 0;
    for (int k = 0; k < 3; k++) begin h_v[k] = 0; h_d[k] = '0; h_tag[k] = "R1"; end
  endtask

  task automatic step(bit v, bit sof, logic [9:0] r, logic [9:0] g, logic [9:0] b,
                      bit we = 0, logic [7:0] a = 8'h0, logic [31:0] d = 32'h0);
    bit old_pend;
    @(negedge clk);
    chk({h_tag[2], "/R7"}, "valid", {31'b0, out_valid}, {31'b0, h_v[2]});
    if (h_v[2]) chk(h_tag[2], "pixel", {2'b0, out_r, out_g, out_b}, {2'b0, h_d[2]});
    h_v[2] = h_v[1]; h_d[2] = h_d[1]; h_tag[2] = h_tag[1];
    h_v[1] = h_v[0]; h_d[1] = h_d[0]; h_tag[1] = h_tag[0];
    pix_valid = v; pix_sof = sof; pix_r = r; pix_g = g; pix_b = b;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    old_pend = pend_m;
    if (v && sof && pend_m) begin
      ac_m = sh_m; ac_en_m = sh_en_m; pend_m = 0;
    end
    h_v[0] = v; h_d[0] = v ? model_px(r, g, b) : '0; h_tag[0] = cur_tag;
    if (we && !old_pend) begin
      if (a == 8'h40) begin
        sh_en_m = d[4];
        if (d[0]) pend_m = 1;
      end else if (a[1:0] == 2'b00 && a < 8'd48) begin
        sh_m[a >> 2] = sx15(d[14:0]);
      end
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    step(0, 0, 0, 0, 0, 1, a, d);
  endtask

  task automatic px(bit sof, logic [9:0] r, logic [9:0] g, logic [9:0] b);
    step(1, sof, r, g, b);
  endtask

  task automatic load(int c[12], bit en);
    for (int k = 0; k < 12; k++) wr(8'(4 * k), 32'(c[k]) & 32'h7fff);
    wr(8'h40, {27'b0, en, 3'b0, 1'b1});
  endtask

  task automatic flush();
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    int c[12];
    void'($urandom(32'd20240611));
    reset_model();
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;

    cur_tag = "R1";
    px(1, 10'd5, 10'd600, 10'd1023);
    flush();

    cur_tag = "R6";
    for (int k = 0; k < 8; k++) px(k == 0, 10'($urandom), 10'($urandom), 10'($urandom));
    flush();

    cur_tag = "R8";
    wr(8'h00, 32'h7000);
    wr(8'h24, 32'h0100);
    wr(8'h40, 32'h10);
    px(1, 10'd100, 10'd200, 10'd300);
    px(0, 10'd1, 10'd2, 10'd3);
    flush();

    cur_tag = "R9";
    c = '{4096, 0, 0, 0, 0, 4096, 0, 4096, 0, 7, -3, 0};
    load(c, 1);
    px(0, 10'd100, 10'd200, 10'd300);
    px(1, 10'd100, 10'd200, 10'd300);
    px(0, 10'd10, 10'd1, 10'd900);
    flush();

    cur_tag = "R2";
    for (int k = 0; k < 12; k++) c[k] = 0;
    c[2] = 4096; c[3] = 2048; c[7] = -4096; c[11] = 1000;
    load(c, 1);
    wr(8'h30, 32'h1234);
    px(1, 10'd400, 10'd10, 10'd20);
    flush();

    cur_tag = "R4";
    for (int k = 0; k < 12; k++) c[k] = 0;
    c[0] = 2048; c[4] = -2048; c[10] = 2; c[8] = 1365;
    load(c, 1);
    px(1, 10'd1, 10'd1, 10'd3);
    px(0, 10'd3, 10'd3, 10'd1);
    px(0, 10'd5, 10'd7, 10'd2);
    flush();

    cur_tag = "R5";
    c = '{16383, 16383, 16383, -16384, 0, 0, 0, 0, 4096, 0, 0, 16383};
    load(c, 1);
    px(1, 10'd1023, 10'd1023, 10'd1023);
    px(0, 10'd1023, 10'd0, 10'd0);
    px(0, 10'd0, 10'd0, 10'd0);
    flush();

    cur_tag = "R10";
    c = '{4096, 0, 0, 0, 4096, 0, 0, 0, 4096, 0, 0, 0};
    load(c, 1);
    wr(8'h00, 32'h0000);
    wr(8'h40, 32'h00);
    px(1, 10'd77, 10'd88, 10'd99);
    flush();

    cur_tag = "R3";
    for (int k = 0; k < 12; k++) c[k] = int'($signed(15'($urandom))) >>> 2;
    load(c, 1);
    px(1, 10'd512, 10'd256, 10'd128);
    for (int n = 0; n < 3000; n++) begin
      bit we = ($urandom % 16) == 0;
      logic [7:0] a = (($urandom % 14) == 0) ? 8'h40 : 8'(4 * ($urandom % 12));
      logic [31:0] d = (a == 8'h40) ? {27'b0, ($urandom % 4) != 0, 3'b0, ($urandom % 3) == 0}
                                    : 32'($urandom);
      bit v = ($urandom % 4) != 0;
      bit sof = v && (($urandom % 40) == 0);
      step(v, sof, 10'($urandom), 10'($urandom), 10'($urandom), we, a, d);
    end
    flush();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule